// File: doc/BRIEF.md
# Card Slot Status and Insertion Interrupt Register Block

This block is a small word-indexed register file that sits beside a removable memory-card slot. It samples two asynchronous inputs from the slot: a write-protect level and a card-present level. The write-protect level is reported live in a status register. A rising card-present level is captured as a sticky insertion flag, which also drives an interrupt line to the system interrupt controller.

Software reads the status register to find out why the interrupt fired, and acknowledges it by writing a one to the insertion flag's bit position in the same register. Removing the card never clears the flag; only the acknowledge write does. The block also holds a read-only identity word and two placeholder registers that accept writes and read back zero.

Both slot inputs pass through a parameterised synchroniser. The card-present level is then edge-detected, so a card that stays inserted raises the flag only once.

Top module: `slot_ctl_regs`

## Requirements
- R1: After reset the status register (word index 2) reads zero and `irq_out` is low.
- R2: Status bit 0 equals `wp_in` delayed by SYNC_STAGES clock edges. It follows the level in both directions and never affects `irq_out`.
- R3: A rising edge of the synchronised `card_in` sets status bit 3 on the next clock edge. `irq_out` is high exactly while bit 3 is set.
- R4: Bit 3 stays set when `card_in` falls. A `card_in` level held high sets bit 3 only once, so after an acknowledge the bit stays clear until the card is removed and inserted again.
- R5: A write to word index 2 whose data has bit 3 set clears status bit 3 on that clock edge, and `irq_out` falls with it. A write to index 2 with data bit 3 clear leaves bit 3 unchanged. No write changes bit 0.
- R6: When a synchronised rising edge and a clearing write fall in the same cycle, bit 3 ends up set.
- R7: Reading word index 0 returns the parameter ID_VALUE.
- R8: Word indices 1 and 3 and all indices above 3 read zero. Writes to them change nothing.
- R9: `bus_rdata` is zero in any cycle without a read strobe (`bus_sel` high and `bus_wr` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | IDX_W | Word index of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the strobe, index and state |
| wp_in | input | 1 | Asynchronous write-protect level from the slot |
| card_in | input | 1 | Asynchronous card-present level from the slot |
| irq_out | output | 1 | Insertion interrupt, high while the flag is set |

## Verification
On every cycle the assertions check the flag's update rules: a synchronised edge sets it, the flag holds without an acknowledge, an acknowledge clears it, and an edge that meets an acknowledge wins. They also check that the interrupt matches the flag seen in a status read, and that idle cycles and unmapped indices return zero. Only the bench's scenarios can show the end-to-end behaviour. These scenarios cover the input-to-register latency through the synchroniser, the fact that a held card raises the flag only once, the exact cycle in which a rising edge coincides with a clearing write, and the fact that writes to placeholder indices leave the status untouched.

// File: rtl/slot_ctl_pkg.sv
`timescale 1ns/1ps
package slot_ctl_pkg;
    // Word indices decoded by the block
    localparam int IDX_ID    = 0;
    localparam int IDX_FLASH = 1;
    localparam int IDX_STAT  = 2;
    localparam int IDX_DEC   = 3;
    // Field positions inside the status word
    localparam int BIT_WP    = 0;
    localparam int BIT_INS   = 3;
endpackage

// File: rtl/slot_sync.sv
`timescale 1ns/1ps
module slot_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.chain[STAGES-1];
endmodule

// File: rtl/slot_latch.sv
`timescale 1ns/1ps
module slot_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic flag;
    } latch_t;

    latch_t l_d, l_q;
    logic   rise;

    always_comb begin
        rise      = lvl & ~l_q.prev;
        l_d.prev  = lvl;
        l_d.flag  = rise | (l_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign flag = l_q.flag;

    // R3: an edge sets the flag on the next edge
    p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> flag);
    // R4: without an acknowledge the flag holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
    // R4: no edge, no flag
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !rise |=> !flag);
    // R5: acknowledge without an edge clears
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !rise |=> !flag);
    // R6: edge and acknowledge together leave the flag set
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise && clr |=> flag);
endmodule

// File: rtl/slot_rdmux.sv
`timescale 1ns/1ps
module slot_rdmux import slot_ctl_pkg::*; #(
    parameter int              IDX_W    = 4,
    parameter int              DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wp,
    input  logic              ins,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (idx)
                IDX_W'(IDX_ID): rdata = ID_VALUE;
                IDX_W'(IDX_STAT): begin
                    rdata[BIT_WP]  = wp;
                    rdata[BIT_INS] = ins;
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/slot_ctl_regs.sv
`timescale 1ns/1ps
module slot_ctl_regs import slot_ctl_pkg::*; #(
    parameter int                IDX_W       = 4,
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_VALUE    = 32'h5107_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              irq_out
);
    logic rd_en;
    logic ack;
    logic wp_s;
    logic card_s;
    logic ins_flag;
    logic unused_wdata;

    always_comb begin
        rd_en = bus_sel & ~bus_wr;
        ack   = bus_sel & bus_wr & (bus_idx == IDX_W'(IDX_STAT)) & bus_wdata[BIT_INS];
    end

    assign unused_wdata = ^{bus_wdata[DATA_W-1:BIT_INS+1], bus_wdata[BIT_INS-1:0]};

    slot_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({card_in, wp_in}),
        .q     ({card_s, wp_s})
    );

    slot_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (card_s),
        .clr   (ack),
        .flag  (ins_flag)
    );

    slot_rdmux #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_rd (
        .rd_en (rd_en),
        .idx   (bus_idx),
        .wp    (wp_s),
        .ins   (ins_flag),
        .rdata (bus_rdata)
    );

    assign irq_out = ins_flag;

    // R3: a status read shows the same flag that drives the interrupt
    p_irq_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_idx == IDX_W'(IDX_STAT) |-> bus_rdata[BIT_INS] == irq_out);
    // R8: unmapped and placeholder indices read zero
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_idx != IDX_W'(IDX_ID) && bus_idx != IDX_W'(IDX_STAT)
        |-> bus_rdata == '0);
    // R9: no read strobe, no data
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> bus_rdata == '0);
endmodule

// File: tb/sim_slot_ctl_regs.sv
`timescale 1ns/1ps
module sim_slot_ctl_regs;
    localparam int          IW = 4;
    localparam int          DW = 32;
    localparam int          ST = 2;
    localparam logic [31:0] IDV = 32'h5107_C0DE;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_sel = 0, bus_wr = 0;
    logic [IW-1:0] bus_idx = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          wp_in = 0, card_in = 0;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    slot_ctl_regs #(.IDX_W(IW), .DATA_W(DW), .SYNC_STAGES(ST), .ID_VALUE(IDV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wp_in(wp_in), .card_in(card_in), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: input history queues and a sticky flag
    bit m_cdq[$];
    bit m_wpq[$];
    bit m_flag, m_prev, m_cd, m_wp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cdq.delete(); m_wpq.delete();
            m_flag = 0; m_prev = 0; m_cd = 0; m_wp = 0;
        end else begin
            bit ackw, edge_seen;
            ackw = bus_sel && bus_wr && bus_idx == 2 && bus_wdata[3];
            edge_seen = m_cd && !m_prev;
            m_flag = edge_seen || (m_flag && !ackw);
            m_prev = m_cd;
            m_cdq.push_back(card_in);
            m_wpq.push_back(wp_in);
            if (m_cdq.size() > ST) begin
                void'(m_cdq.pop_front());
                void'(m_wpq.pop_front());
            end
            m_cd = (m_cdq.size() == ST) ? m_cdq[0] : 1'b0;
            m_wp = (m_wpq.size() == ST) ? m_wpq[0] : 1'b0;
        end
    end

    function automatic logic [31:0] model_rd();
        if (!(bus_sel && !bus_wr)) return 32'h0;
        if (bus_idx == 0) return IDV;
        if (bus_idx == 2) return {28'h0, m_flag, 2'b00, m_wp};
        return 32'h0;
    endfunction

    // Cycle-by-cycle comparison against the reference
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            check(irq_out === m_flag, "R3 irq vs model", {31'h0, irq_out}, {31'h0, m_flag});
            check(bus_rdata === model_rd(), "R8 rdata vs model", bus_rdata, model_rd());
        end
    end

    task automatic rd(input int idx, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_idx = IW'(idx);
        #2 data = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_idx = IW'(idx); bus_wdata = data;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        idle(1);

        // R1: reset state
        rd(2, v);
        check(v == 32'h0, "R1 status after reset", v, 32'h0);
        check(irq_out == 1'b0, "R1 irq after reset", {31'h0, irq_out}, 32'h0);

        // R7: identity word
        rd(0, v);
        check(v == IDV, "R7 id word", v, IDV);

        // R2: write-protect follows the level, no interrupt
        @(negedge clk) wp_in = 1;
        idle(ST + 1);
        rd(2, v);
        check(v == 32'h1, "R2 wp set", v, 32'h1);
        check(irq_out == 1'b0, "R2 wp no irq", {31'h0, irq_out}, 32'h0);
        @(negedge clk) wp_in = 0;
        idle(ST + 1);
        rd(2, v);
        check(v == 32'h0, "R2 wp cleared", v, 32'h0);

        // R3: insertion sets the flag and the interrupt
        @(negedge clk) card_in = 1;
        idle(ST + 2);
        rd(2, v);
        check(v == 32'h8, "R3 flag set", v, 32'h8);
        check(irq_out == 1'b1, "R3 irq high", {31'h0, irq_out}, 32'h1);

        // R5: acknowledge without bit 3 leaves the flag
        @(negedge clk) wp_in = 1;
        idle(ST + 1);
        wr(2, 32'hFFFF_FFF7);
        rd(2, v);
        check(v == 32'h9, "R5 write without bit 3 keeps flag", v, 32'h9);
        wr(2, 32'h0000_0008);
        rd(2, v);
        check(v == 32'h1, "R5 clear keeps wp", v, 32'h1);
        check(irq_out == 1'b0, "R5 irq low after clear", {31'h0, irq_out}, 32'h0);

        // R4: a held card does not set the flag again
        idle(6);
        rd(2, v);
        check(v == 32'h1, "R4 held card sets once", v, 32'h1);

        // R4: removal does not clear the flag
        @(negedge clk) card_in = 0;
        idle(ST + 1);
        @(negedge clk) card_in = 1;
        idle(ST + 2);
        @(negedge clk) card_in = 0;
        idle(ST + 3);
        rd(2, v);
        check(v == 32'h9, "R4 flag survives removal", v, 32'h9);

        // R6: edge meets an acknowledge in the same cycle
        @(negedge clk) card_in = 1;
        idle(ST - 1);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_idx = 2; bus_wdata = 32'h8;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        rd(2, v);
        check(v == 32'h9, "R6 set wins over clear", v, 32'h9);
        check(irq_out == 1'b1, "R6 irq stays high", {31'h0, irq_out}, 32'h1);

        // R8: placeholder and unmapped indices
        wr(1, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        wr(15, 32'hFFFF_FFFF);
        rd(2, v);
        check(v == 32'h9, "R8 writes elsewhere leave status", v, 32'h9);
        rd(1, v);
        check(v == 32'h0, "R8 index 1 reads zero", v, 32'h0);
        rd(3, v);
        check(v == 32'h0, "R8 index 3 reads zero", v, 32'h0);
        rd(9, v);
        check(v == 32'h0, "R8 index 9 reads zero", v, 32'h0);

        // R9: no read strobe gives zero
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_idx = 0;
        #2 check(bus_rdata == 32'h0, "R9 idle zero", bus_rdata, 32'h0);
        bus_sel = 1; bus_wr = 1; bus_idx = 0;
        #2 check(bus_rdata == 32'h0, "R9 write cycle zero", bus_rdata, 32'h0);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;

        idle(4);
        finish_up();
    end
endmodule